// File: doc/BRIEF.md
# HDLC Transmitter with Shared Flags

This block turns bytes written by a processor into a bit-serial HDLC stream for a framer's signalling data link. Each frame gets an opening flag (0x7E), a CRC-16 frame check sequence and a closing flag, and zero-bit stuffing is applied to the frame body. A programmable idle byte fills the link between frames. The stream moves forward only in bit slots that an external strobe marks as data-link positions. Placing those bits into the T1 or E1 frame is done elsewhere.

Bytes go into a 64-byte buffer made of two 32-byte halves. A request output tells the processor when a whole half is free to refill. The processor marks the last byte of a frame with an end-of-frame bit, and that bit triggers the CRC and the closing flag. If the buffer runs dry in the middle of a frame, the frame is aborted with a run of ones and a one-cycle underrun pulse is raised. With shared-flag mode enabled, the closing flag of one frame is also the opening flag of the next frame when one is waiting.

Top module: `hdlc_flag_tx`

## Requirements
- R1: After reset `tx_bit` presents bit 0 of `idle_code`, `half_req` is 1 and `underrun` is 0.
- R2: A frame is sent as flag 0x7E, then each data byte least significant bit first, in write order. Flags are sent LSB first (0,1,1,1,1,1,1,0).
- R3: After the byte with `wr_eof`=1, the block sends 16 check bits: the ones complement of a CRC-16 (reflected polynomial 0x8408, i.e. x^16+x^12+x^5+1), preset to 0xFFFF and run over the frame's data bits, sent low-order bit first.
- R4: Within data and check bits, a 0 is inserted after every five consecutive 1s. This includes a 0 after the final check bit when that bit completes a run of five. Flags, idle bytes and aborts are never stuffed.
- R5: The sequence advances by one bit only on a rising clock edge with `slot_en`=1. Otherwise the position is held.
- R6: Between frames `idle_code` is sent LSB first in whole bytes. A frame begins at an idle byte boundary when at least one byte is buffered.
- R7: With `shared_en`=1 and a byte buffered when a closing flag completes, the next frame's first data bit follows that flag directly, with no second flag.
- R8: With `shared_en`=0, or nothing buffered, the closing flag is followed by at least one whole idle byte before the next opening flag.
- R9: If the buffer is empty when a non-final data byte completes, the block sends eight 1s, pulses `underrun` high for exactly one cycle after the entering slot, and then returns to idle bytes.
- R10: The buffer holds 64 bytes (two halves of 32). `half_req` is 1 exactly when no more than 32 bytes are stored.
- R11: A write while 64 bytes are stored is discarded and never appears on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one byte into the buffer |
| wr_data | input | 8 | Byte to write |
| wr_eof | input | 1 | The written byte ends its frame |
| shared_en | input | 1 | Let one flag both close and open frames |
| idle_code | input | 8 | Byte sent between frames |
| slot_en | input | 1 | This cycle is a data-link bit slot |
| tx_bit | output | 1 | Serial bit for the current slot |
| half_req | output | 1 | At least one 32-byte half is free |
| underrun | output | 1 | One-cycle pulse on a mid-frame abort |

## Verification
Short frames of arbitrary bytes with an all-ones idle byte check byte order and the check sequence. Bodies packed with 0xFF and with embedded 0x7E values, sent with a flag-valued idle byte and sparse slots, separate stuffing from flags and show that the position is held between slots. Back-to-back frames are sent once with the shared flag and once without, to tell a single shared flag from a close–idle–open gap. A frame with no end marker causes an abort. A 64-byte frame followed by two extra writes shows the half request falling and rising and shows that overflow writes are dropped.

// File: rtl/hdlc_tx_pkg.sv
// Shared constants and types for the HDLC transmitter.
package hdlc_tx_pkg;
    localparam logic [7:0]  FLAG_BYTE     = 8'h7E;
    localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
    localparam logic [15:0] CRC_PRESET    = 16'hFFFF;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPEN, ST_DATA, ST_CRC, ST_TAIL, ST_CLOSE, ST_ABORT
    } tx_state_t;

    typedef struct packed {
        logic       eof;
        logic [7:0] data;
    } fifo_word_t;
endpackage

// File: rtl/hdlc_tx_fifo.sv
// Byte buffer of two equal halves. The head is read combinationally and
// pop advances it. Writes while full are dropped. half_free reports room
// for one whole half. Assumes the caller never pops when empty.
module hdlc_tx_fifo
    import hdlc_tx_pkg::*;
#(
    parameter int HALF_BYTES = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  fifo_word_t wr_word,
    input  logic       pop,
    output fifo_word_t head,
    output logic       empty,
    output logic       full,
    output logic       half_free
);
    localparam int DEPTH = 2 * HALF_BYTES;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);

    fifo_word_t     mem [DEPTH];
    logic [AW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  count;
    logic           push;

    assign push      = wr_en && !full;
    assign empty     = (count == '0);
    assign full      = (count == CW'(DEPTH));
    assign half_free = (count <= CW'(HALF_BYTES));
    assign head      = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_word;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_full_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !pop) |=> (count == $past(count)));
endmodule

// File: rtl/hdlc_tx_crc16.sv
// Bit-serial reflected CRC-16. crc_next gives the value after absorbing
// bit_in, so the caller can capture the final check word on the same edge.
module hdlc_tx_crc16
    import hdlc_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        bit_en,
    input  logic        bit_in,
    output logic [15:0] crc_next
);
    logic [15:0] crc_q;

    // One shift step of the reflected polynomial.
    always_comb begin
        crc_next = {1'b0, crc_q[15:1]};
        if (crc_q[0] ^ bit_in) crc_next = crc_next ^ CRC_POLY_REFL;
    end

    // Remainder register: preset per frame, stepped per data bit.
    always_ff @(posedge clk) begin
        if (!rst_n || init) crc_q <= CRC_PRESET;
        else if (bit_en)    crc_q <= crc_next;
    end

    assert_crc_preset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (crc_q == CRC_PRESET));
endmodule

// File: rtl/hdlc_tx_ctrl.sv
// Bit sequencer: walks idle, flag, data, check, stuff-tail and abort
// phases, one bit per strobed slot. Assumes head is valid whenever empty
// is low and that slot_en marks every usable link bit.
module hdlc_tx_ctrl
    import hdlc_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slot_en,
    input  logic        shared_en,
    input  logic [7:0]  idle_code,
    input  fifo_word_t  head,
    input  logic        empty,
    input  logic [15:0] crc_next,
    output logic        pop,
    output logic        crc_init,
    output logic        crc_bit_en,
    output logic        crc_bit,
    output logic        tx_bit,
    output logic        underrun
);
    tx_state_t   state;
    logic [3:0]  idx;
    logic [15:0] shreg;
    logic [2:0]  ones, ones_next;
    logic        last_q, stuff_now, byte_end, chain;

    assign stuff_now  = (state == ST_DATA || state == ST_CRC) && (ones == 3'd5);
    assign byte_end   = (idx[2:0] == 3'd7);
    assign chain      = shared_en && !empty;
    assign crc_bit    = shreg[0];
    assign crc_bit_en = slot_en && (state == ST_DATA) && !stuff_now;
    assign ones_next  = tx_bit ? ones + 1'b1 : 3'd0;
    assign crc_init   = slot_en && byte_end &&
                        ((state == ST_OPEN) || (state == ST_CLOSE && chain));
    assign pop        = crc_init ||
                        (slot_en && state == ST_DATA && !stuff_now && byte_end &&
                         !last_q && !empty);

    // Current line bit for the phase and position.
    always_comb begin
        unique case (state)
            ST_IDLE:           tx_bit = idle_code[idx[2:0]];
            ST_OPEN, ST_CLOSE: tx_bit = FLAG_BYTE[idx[2:0]];
            ST_DATA, ST_CRC:   tx_bit = stuff_now ? 1'b0 : shreg[0];
            ST_TAIL:           tx_bit = 1'b0;
            default:           tx_bit = 1'b1;
        endcase
    end

    // Phase sequencing, advanced only in strobed slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            shreg    <= '0;
            ones     <= '0;
            last_q   <= 1'b0;
            underrun <= 1'b0;
        end else begin
            underrun <= 1'b0;
            if (slot_en) begin
                if (stuff_now) begin
                    ones <= '0;
                end else begin
                    unique case (state)
                        ST_IDLE: begin
                            idx <= byte_end ? 4'd0 : idx + 1'b1;
                            if (byte_end && !empty) state <= ST_OPEN;
                        end
                        ST_OPEN: begin
                            idx <= byte_end ? 4'd0 : idx + 1'b1;
                            if (byte_end) state <= ST_DATA;
                        end
                        ST_DATA: begin
                            ones  <= ones_next;
                            shreg <= {1'b0, shreg[15:1]};
                            idx   <= byte_end ? 4'd0 : idx + 1'b1;
                            if (byte_end && last_q) begin
                                state <= ST_CRC;
                                shreg <= ~crc_next;
                            end else if (byte_end && empty) begin
                                state    <= ST_ABORT;
                                underrun <= 1'b1;
                            end
                        end
                        ST_CRC: begin
                            ones  <= ones_next;
                            shreg <= {1'b0, shreg[15:1]};
                            idx   <= (idx == 4'd15) ? 4'd0 : idx + 1'b1;
                            if (idx == 4'd15)
                                state <= (ones_next == 3'd5) ? ST_TAIL : ST_CLOSE;
                        end
                        ST_TAIL: state <= ST_CLOSE;
                        ST_CLOSE: begin
                            idx <= byte_end ? 4'd0 : idx + 1'b1;
                            if (byte_end) state <= chain ? ST_DATA : ST_IDLE;
                        end
                        default: begin
                            idx <= byte_end ? 4'd0 : idx + 1'b1;
                            if (byte_end) state <= ST_IDLE;
                        end
                    endcase
                end
                if (pop) begin
                    shreg  <= {8'h00, head.data};
                    last_q <= head.eof;
                end
                if (crc_init) ones <= '0;
            end
        end
    end

    // Checker-only count of consecutive transmitted ones inside a frame.
    logic [2:0] chk_run;
    always_ff @(posedge clk) begin
        if (!rst_n || crc_init) chk_run <= '0;
        else if (slot_en && (state == ST_DATA || state == ST_CRC || state == ST_TAIL))
            chk_run <= tx_bit ? ((chk_run == 3'd7) ? chk_run : chk_run + 1'b1) : 3'd0;
    end

    assert_no_six_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_en && (state == ST_DATA || state == ST_CRC) && tx_bit) |-> (chk_run < 3'd5));
    assert_underrun_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun);
    assert_abort_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> (state == ST_ABORT));
    assert_hold_without_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_en |=> ($stable(state) && $stable(idx)));
endmodule

// File: rtl/hdlc_flag_tx.sv
// Top of the HDLC transmitter: buffer, CRC unit and bit sequencer.
// Assumes slot_en is already aligned to data-link bit positions.
module hdlc_flag_tx
    import hdlc_tx_pkg::*;
#(
    parameter int HALF_BYTES = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wr_eof,
    input  logic       shared_en,
    input  logic [7:0] idle_code,
    input  logic       slot_en,
    output logic       tx_bit,
    output logic       half_req,
    output logic       underrun
);
    fifo_word_t  head, wr_word;
    logic        empty, full, pop, crc_init, crc_bit_en, crc_bit;
    logic [15:0] crc_next;

    assign wr_word = '{eof: wr_eof, data: wr_data};

    hdlc_tx_fifo #(.HALF_BYTES(HALF_BYTES)) i_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .pop(pop),
        .head(head), .empty(empty), .full(full), .half_free(half_req)
    );

    hdlc_tx_crc16 i_crc (
        .clk(clk), .rst_n(rst_n), .init(crc_init), .bit_en(crc_bit_en),
        .bit_in(crc_bit), .crc_next(crc_next)
    );

    hdlc_tx_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .shared_en(shared_en),
        .idle_code(idle_code), .head(head), .empty(empty), .crc_next(crc_next),
        .pop(pop), .crc_init(crc_init), .crc_bit_en(crc_bit_en), .crc_bit(crc_bit),
        .tx_bit(tx_bit), .underrun(underrun)
    );

    assert_half_req_not_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        half_req |-> !full);
endmodule

// File: tb/test_hdlc_flag_tx.sv
// Bench: behavioural line model compared with the outputs every cycle.
module test_hdlc_flag_tx;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_eof = 1'b0, shared_en = 1'b0, slot_en = 1'b0;
    logic [7:0] wr_data = 8'h00, idle_code = 8'hFF;
    logic       tx_bit, half_req, underrun;

    always #5 clk = ~clk;

    hdlc_flag_tx i_hdlc_flag_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_eof(wr_eof),
        .shared_en(shared_en), .idle_code(idle_code), .slot_en(slot_en),
        .tx_bit(tx_bit), .half_req(half_req), .underrun(underrun)
    );

    int errors = 0, checks = 0, und_seen = 0, slot_mode = 2;
    bit full_test = 0, prev_slot = 0;
    logic [15:0] lf = 16'hACE1;

    // Model: phases 0 idle,1 open,2 data,3 check,4 tail stuff,5 close,6 abort
    logic [8:0]  mq[$];
    int          m_ph = 0, m_idx = 0, m_ones = 0;
    logic [15:0] m_sh = 0, m_crc = 16'hFFFF;
    bit          m_last = 0, m_und = 0;

    function automatic bit m_stuff();
        return (m_ph == 2 || m_ph == 3) && m_ones == 5;
    endfunction

    function automatic bit m_bit();
        if (m_stuff()) return 1'b0;
        case (m_ph)
            0:       return idle_code[m_idx];
            1, 5:    return (m_idx == 0 || m_idx == 7) ? 1'b0 : 1'b1;
            2, 3:    return m_sh[0];
            4:       return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic m_load();
        logic [8:0] w = mq.pop_front();
        m_sh = {8'h00, w[7:0]};
        m_last = w[8];
    endtask

    task automatic m_start();
        m_crc = 16'hFFFF; m_ones = 0; m_load(); m_ph = 2;
    endtask

    task automatic m_step();
        bit b = m_bit();
        if (m_stuff()) begin m_ones = 0; return; end
        case (m_ph)
            0: if (m_idx == 7) begin m_idx = 0; if (mq.size() > 0) m_ph = 1; end else m_idx++;
            1: if (m_idx == 7) begin m_idx = 0; m_start(); end else m_idx++;
            2: begin
                m_crc = (m_crc >> 1) ^ ((m_crc[0] ^ b) ? 16'h8408 : 16'h0000);
                m_ones = b ? m_ones + 1 : 0;
                m_sh = m_sh >> 1;
                if (m_idx == 7) begin
                    m_idx = 0;
                    if (m_last) begin m_ph = 3; m_sh = ~m_crc; end
                    else if (mq.size() == 0) begin m_ph = 6; m_und = 1; end
                    else m_load();
                end else m_idx++;
            end
            3: begin
                m_ones = b ? m_ones + 1 : 0;
                m_sh = m_sh >> 1;
                if (m_idx == 15) begin m_idx = 0; m_ph = (m_ones == 5) ? 4 : 5; end
                else m_idx++;
            end
            4: m_ph = 5;
            5: if (m_idx == 7) begin
                   m_idx = 0;
                   if (shared_en && mq.size() > 0) m_start(); else m_ph = 0;
               end else m_idx++;
            default: if (m_idx == 7) begin m_idx = 0; m_ph = 0; end else m_idx++;
        endcase
    endtask

    // Model update at the same edge the design registers on.
    always @(posedge clk) begin
        bit full_pre;
        if (!rst_n) begin
            mq.delete(); m_ph = 0; m_idx = 0; m_ones = 0; m_sh = 0; m_last = 0; m_und = 0;
        end else begin
            full_pre = (mq.size() >= 64);
            m_und = 0;
            if (slot_en) m_step();
            if (wr_en && !full_pre) mq.push_back({wr_eof, wr_data});
        end
    end

    // Slot strobe pattern: 0 every cycle, 1 pseudo-random, 2 none.
    always @(negedge clk) begin
        prev_slot <= slot_en;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        slot_en = (slot_mode == 0) ? 1'b1 : (slot_mode == 1) ? lf[0] : 1'b0;
    end

    task automatic check(input bit got, input bit exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    function automatic string tag();
        string t;
        case (m_ph)
            0: t = "R6";
            1: t = "R2";
            2: t = m_stuff() ? "R4" : "R2";
            3: t = m_stuff() ? "R4" : "R3";
            4: t = "R4";
            5: t = shared_en ? "R7" : "R8";
            default: t = "R9";
        endcase
        if (!prev_slot) t = {t, "/R5"};
        if (full_test) t = {t, "/R11"};
        return t;
    endfunction

    // Every-cycle comparison, just after the inputs settle.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            check(tx_bit, m_bit(), tag());
            check(half_req, mq.size() <= 32, "R10");
            check(underrun, m_und, "R9");
            if (underrun) und_seen++;
        end
    end

    task automatic put(input logic [7:0] d, input bit eof);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_eof = eof;
        @(negedge clk);
        wr_en = 1'b0; wr_eof = 1'b0;
    endtask

    task automatic wait_done();
        while (!(m_ph == 0 && mq.size() == 0)) @(negedge clk);
        repeat (24) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state at the ports
        check(tx_bit, idle_code[0], "R1");
        check(half_req, 1'b1, "R1");
        check(underrun, 1'b0, "R1");

        // R2/R3: plain frame, every slot
        slot_mode = 0;
        put(8'h12, 0); put(8'h34, 0); put(8'h56, 1);
        wait_done();

        // R4/R5: ones-heavy body, flag-valued idle, sparse slots
        idle_code = 8'h7E; slot_mode = 1;
        put(8'hFF, 0); put(8'hFF, 0); put(8'h7E, 0); put(8'hF8, 0); put(8'h3F, 1);
        wait_done();

        // R7: back-to-back frames sharing one flag
        idle_code = 8'hFF; shared_en = 1'b1;
        put(8'hA5, 0); put(8'h0F, 1); put(8'hC3, 0); put(8'hFF, 1);
        wait_done();

        // R8: same pattern with shared flags off
        shared_en = 1'b0;
        put(8'hA5, 0); put(8'h0F, 1); put(8'hC3, 0); put(8'hFF, 1);
        wait_done();

        // R9: frame with no end marker runs dry
        und_seen = 0;
        put(8'h81, 0); put(8'h42, 0);
        wait_done();
        checks++;
        if (und_seen != 1) begin
            errors++;
            $display("FAIL R9: got %0d underrun pulses expected 1", und_seen);
        end

        // R10/R11: fill both halves, then overflow writes
        slot_mode = 2; full_test = 1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 64; i++) put(8'(i * 37 + 5), i == 63);
        put(8'hEE, 1); put(8'hDD, 0);
        #1;
        check(half_req, 1'b0, "R10");
        slot_mode = 0;
        wait_done();
        check(half_req, 1'b1, "R11");
        full_test = 0;
        finish_run();
    end
endmodule